// File: doc/BRIEF.md
# Multicycle Instruction Control Sequencer

This block is the control unit of a non-pipelined processor that runs one instruction at a time over several clock cycles. It reads the opcode and function fields held in the instruction register, together with the ALU zero flag. From them it steps through a fixed chain of phases: fetch, decode, execute, an optional memory access and an optional write-back. In each phase it drives the enables and selects that steer the datapath for that phase.

Five instruction classes are supported: register-to-register ALU operations, add-immediate, load word, store word and branch-if-equal. The number of phases depends on the class. A load uses all five phases. ALU operations, add-immediate and stores use four. A branch uses three. An opcode that is not recognised leaves after decode. The surrounding datapath keeps the instruction register steady from the end of fetch until the next fetch.

Top module: `mcc_ctrl_unit`

## Requirements
- R1: After reset the phases run fetch, decode, execute. In fetch only `pc_write` and `ir_load` are high. In decode no enable is high. In every phase other than execute, `alu_op` is 0010 (add) and `alu_src` is 0.
- R2: Opcode 000000 with a supported funct is a register-to-register operation. In execute `alu_op` follows funct: 100100 gives 0000 (AND), 100101 gives 0001 (OR), 100000 gives 0010 (ADD), 100010 gives 0110 (SUB), 100111 gives 1100 (NOR) and 101010 gives 0111 (SLT). The next phase is write-back with `reg_write`=1, `reg_dst`=1 and `mem_to_reg`=0. Fetch follows.
- R3: Opcode 001000 (add-immediate) drives `alu_op`=0010 with `alu_src`=1 in execute. Write-back follows with `reg_write`=1, `reg_dst`=0 and `mem_to_reg`=0.
- R4: Opcode 100011 (load) drives add with `alu_src`=1 in execute. A memory phase with only `mem_read` high follows, then write-back with `reg_write`=1 and `mem_to_reg`=1, so the instruction takes five cycles.
- R5: Opcode 101011 (store) drives add with `alu_src`=1 in execute. A memory phase with only `mem_write` high follows, then fetch, with no register write.
- R6: Opcode 000100 (branch-if-equal) drives `alu_op`=0110 and `branch`=1 in execute, with `pc_write` equal to `alu_zero` in that cycle. Fetch follows.
- R7: An unlisted opcode, or opcode 000000 with an unlisted funct, returns from decode to fetch and raises no write enable.
- R8: For every opcode other than 000000, the funct field has no effect on any output.
- R9: Reset is synchronous and active high. While `rst` is high every output is 0. In the first cycle after `rst` falls the unit is in fetch, even when reset arrives partway through an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_write | output | 1 | Program counter update enable |
| ir_load | output | 1 | Instruction register capture enable |
| reg_write | output | 1 | Register file write enable |
| alu_op | output | 4 | ALU operation select |
| mem_read | output | 1 | Data memory read strobe |
| mem_write | output | 1 | Data memory write strobe |
| mem_to_reg | output | 1 | Write-back data taken from memory |
| reg_dst | output | 1 | Write-back register is rd (1) or rt (0) |
| alu_src | output | 1 | ALU second operand is the immediate |
| branch | output | 1 | Branch-compare phase marker |

## Verification
The bench compares every output in every phase of each instruction class, so a sequencer that used the wrong length for a class shows up as a fetch missing where one is expected. Some tests target specific mistakes:
- A branch tested with the zero flag both clear and set catches a program counter that updates unconditionally.
- Funct values placed on non-register opcodes catch a decoder that looks at funct too early, which would change `alu_op` for loads, stores or branches.
- An unsupported funct under opcode 000000 catches a decoder that writes a register for any funct.
- Reset applied in the execute phase of a load catches a design that finishes the load's memory access or register write after reset, or that resumes in decode instead of fetch.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;
    localparam int ALU_W = 4;
    localparam int NFN   = 6;

    typedef logic [OPC_W-1:0] opcode_t;
    typedef logic [FN_W-1:0]  funct_t;
    typedef logic [ALU_W-1:0] alu_t;

    localparam opcode_t OPC_RTYPE = 6'b000000;
    localparam opcode_t OPC_ADDI  = 6'b001000;
    localparam opcode_t OPC_LW    = 6'b100011;
    localparam opcode_t OPC_SW    = 6'b101011;
    localparam opcode_t OPC_BEQ   = 6'b000100;

    localparam alu_t ALU_AND = 4'b0000;
    localparam alu_t ALU_OR  = 4'b0001;
    localparam alu_t ALU_ADD = 4'b0010;
    localparam alu_t ALU_SUB = 4'b0110;
    localparam alu_t ALU_SLT = 4'b0111;
    localparam alu_t ALU_NOR = 4'b1100;

    typedef enum logic [2:0] {
        PH_FETCH, PH_DECODE, PH_EXEC, PH_MEM, PH_WB
    } phase_e;

    typedef enum logic [2:0] {
        IC_NONE, IC_ALU, IC_ADDI, IC_LOAD, IC_STORE, IC_BRANCH
    } iclass_e;

    typedef struct packed {
        logic pc_we;
        logic ir_ld;
        logic rf_we;
        alu_t alu_sel;
        logic mem_rd;
        logic mem_wr;
        logic wb_from_mem;
        logic dst_rd;
        logic opb_imm;
        logic br;
    } strobes_t;

    // Supported funct encodings, indexed 0..NFN-1
    function automatic funct_t fn_code(int i);
        case (i)
            0:       return 6'b100100;
            1:       return 6'b100101;
            2:       return 6'b100000;
            3:       return 6'b100010;
            4:       return 6'b100111;
            default: return 6'b101010;
        endcase
    endfunction

    // ALU code paired with fn_code(i)
    function automatic alu_t fn_alu(int i);
        case (i)
            0:       return ALU_AND;
            1:       return ALU_OR;
            2:       return ALU_ADD;
            3:       return ALU_SUB;
            4:       return ALU_NOR;
            default: return ALU_SLT;
        endcase
    endfunction

    function automatic iclass_e classify(opcode_t op, logic fn_ok);
        case (op)
            OPC_RTYPE: return fn_ok ? IC_ALU : IC_NONE;
            OPC_ADDI:  return IC_ADDI;
            OPC_LW:    return IC_LOAD;
            OPC_SW:    return IC_STORE;
            OPC_BEQ:   return IC_BRANCH;
            default:   return IC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mcc_alu_decode.sv
module mcc_alu_decode
    import mcc_pkg::*;
(
    input  funct_t funct,
    output alu_t   r_alu,
    output logic   fn_known
);

    logic [NFN-1:0]            hit;
    logic [NFN-1:0][ALU_W-1:0] part;

    for (genvar i = 0; i < NFN; i++) begin : g_fn
        assign hit[i]  = (funct == fn_code(i));
        assign part[i] = hit[i] ? fn_alu(i) : '0;
    end

    always_comb begin
        r_alu = '0;
        for (int i = 0; i < NFN; i++) begin
            r_alu = r_alu | part[i];
        end
    end

    assign fn_known = |hit;

endmodule

// File: rtl/mcc_phase_fsm.sv
module mcc_phase_fsm
    import mcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  iclass_e cls,
    output phase_e  ph
);

    phase_e nxt;

    always_comb begin
        case (ph)
            PH_FETCH:  nxt = PH_DECODE;
            PH_DECODE: nxt = (cls == IC_NONE) ? PH_FETCH : PH_EXEC;
            PH_EXEC: begin
                case (cls)
                    IC_LOAD, IC_STORE: nxt = PH_MEM;
                    IC_ALU, IC_ADDI:   nxt = PH_WB;
                    default:           nxt = PH_FETCH;
                endcase
            end
            PH_MEM:    nxt = (cls == IC_LOAD) ? PH_WB : PH_FETCH;
            default:   nxt = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_FETCH;
        else     ph <= nxt;
    end

    // R1
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
        ph == PH_FETCH |=> ph == PH_DECODE);

    // R4
    mem_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ph == PH_MEM |-> $past(ph) == PH_EXEC);

    // R5
    store_skips_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_MEM && cls == IC_STORE) |=> ph == PH_FETCH);

    // R7
    unknown_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_DECODE && cls == IC_NONE) |=> ph == PH_FETCH);

endmodule

// File: rtl/mcc_strobe_gen.sv
module mcc_strobe_gen
    import mcc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  phase_e   ph,
    input  iclass_e  cls,
    input  alu_t     r_alu,
    input  logic     zero,
    output strobes_t s
);

    always_comb begin
        s         = '0;
        s.alu_sel = ALU_ADD;
        case (ph)
            PH_FETCH: begin
                s.pc_we = 1'b1;
                s.ir_ld = 1'b1;
            end
            PH_EXEC: begin
                case (cls)
                    IC_ALU:                     s.alu_sel = r_alu;
                    IC_ADDI, IC_LOAD, IC_STORE: s.opb_imm = 1'b1;
                    IC_BRANCH: begin
                        s.alu_sel = ALU_SUB;
                        s.br      = 1'b1;
                        s.pc_we   = zero;
                    end
                    default: ;
                endcase
            end
            PH_MEM: begin
                s.mem_rd = (cls == IC_LOAD);
                s.mem_wr = (cls == IC_STORE);
            end
            PH_WB: begin
                s.rf_we       = (cls == IC_ALU) || (cls == IC_ADDI) || (cls == IC_LOAD);
                s.wb_from_mem = (cls == IC_LOAD);
                s.dst_rd      = (cls == IC_ALU);
            end
            default: ;
        endcase
    end

    // R4
    load_wb_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        s.wb_from_mem |-> $past(s.mem_rd));

    // R6
    branch_returns_chk: assert property (@(posedge clk) disable iff (rst)
        s.br |=> s.ir_ld);

endmodule

// File: rtl/mcc_ctrl_unit.sv
module mcc_ctrl_unit
    import mcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic       alu_zero,
    output logic       pc_write,
    output logic       ir_load,
    output logic       reg_write,
    output logic [3:0] alu_op,
    output logic       mem_read,
    output logic       mem_write,
    output logic       mem_to_reg,
    output logic       reg_dst,
    output logic       alu_src,
    output logic       branch
);

    alu_t     r_alu;
    logic     fn_known;
    iclass_e  cls;
    phase_e   ph;
    strobes_t raw;
    strobes_t so;

    mcc_alu_decode u_alu_dec (
        .funct    (funct),
        .r_alu    (r_alu),
        .fn_known (fn_known)
    );

    assign cls = classify(opcode, fn_known);

    mcc_phase_fsm u_fsm (
        .clk (clk),
        .rst (rst),
        .cls (cls),
        .ph  (ph)
    );

    mcc_strobe_gen u_strb (
        .clk   (clk),
        .rst   (rst),
        .ph    (ph),
        .cls   (cls),
        .r_alu (r_alu),
        .zero  (alu_zero),
        .s     (raw)
    );

    assign so = rst ? '0 : raw;

    assign pc_write   = so.pc_we;
    assign ir_load    = so.ir_ld;
    assign reg_write  = so.rf_we;
    assign alu_op     = so.alu_sel;
    assign mem_read   = so.mem_rd;
    assign mem_write  = so.mem_wr;
    assign mem_to_reg = so.wb_from_mem;
    assign reg_dst    = so.dst_rd;
    assign alu_src    = so.opb_imm;
    assign branch     = so.br;

    // R9
    fetch_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ir_load && pc_write));

endmodule

// File: tb/mcc_ctrl_unit_test.sv
module mcc_ctrl_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opc = 6'b000000;
    logic [5:0] fnc = 6'b000000;
    logic       zf  = 1'b0;

    logic       pc_write, ir_load, reg_write, mem_read, mem_write;
    logic       mem_to_reg, reg_dst, alu_src, branch;
    logic [3:0] alu_op;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    mcc_ctrl_unit uut (
        .clk(clk), .rst(rst), .opcode(opc), .funct(fnc), .alu_zero(zf),
        .pc_write(pc_write), .ir_load(ir_load), .reg_write(reg_write),
        .alu_op(alu_op), .mem_read(mem_read), .mem_write(mem_write),
        .mem_to_reg(mem_to_reg), .reg_dst(reg_dst), .alu_src(alu_src),
        .branch(branch)
    );

    // fields: [16:11] opcode, [10:5] funct, [4] zero, [3:0] requirement number
    localparam logic [16:0] VEC [16] = '{
        {6'b000000, 6'b100100, 1'b0, 4'd2},
        {6'b000000, 6'b100101, 1'b1, 4'd2},
        {6'b000000, 6'b100000, 1'b0, 4'd2},
        {6'b000000, 6'b100010, 1'b0, 4'd2},
        {6'b000000, 6'b100111, 1'b0, 4'd2},
        {6'b000000, 6'b101010, 1'b1, 4'd2},
        {6'b001000, 6'b000000, 1'b0, 4'd3},
        {6'b100011, 6'b000000, 1'b0, 4'd4},
        {6'b101011, 6'b000000, 1'b0, 4'd5},
        {6'b000100, 6'b000000, 1'b1, 4'd6},
        {6'b000100, 6'b000000, 1'b0, 4'd6},
        {6'b111111, 6'b100000, 1'b0, 4'd7},
        {6'b000000, 6'b000000, 1'b0, 4'd7},
        {6'b001000, 6'b101010, 1'b0, 4'd8},
        {6'b101011, 6'b100010, 1'b1, 4'd8},
        {6'b000100, 6'b100111, 1'b1, 4'd8}
    };

    function automatic string req_name(int n);
        case (n)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    // 0 unknown, 1 register op, 2 add-immediate, 3 load, 4 store, 5 branch
    function automatic int kind_of(logic [5:0] op, logic [5:0] fn);
        if (op == 6'b000000)
            return (fn inside {6'b100100, 6'b100101, 6'b100000,
                               6'b100010, 6'b100111, 6'b101010}) ? 1 : 0;
        case (op)
            6'b001000: return 2;
            6'b100011: return 3;
            6'b101011: return 4;
            6'b000100: return 5;
            default:   return 0;
        endcase
    endfunction

    function automatic int len_of(int kd);
        case (kd)
            3:       return 5;
            1, 2, 4: return 4;
            5:       return 3;
            default: return 2;
        endcase
    endfunction

    function automatic logic [3:0] r_code(logic [5:0] fn);
        case (fn)
            6'b100100: return 4'b0000;
            6'b100101: return 4'b0001;
            6'b100000: return 4'b0010;
            6'b100010: return 4'b0110;
            6'b100111: return 4'b1100;
            default:   return 4'b0111;
        endcase
    endfunction

    function automatic logic [13:0] exp_vec(int k, int kd, logic [5:0] fn, logic z);
        logic pcw = 0, irl = 0, rw = 0, mr = 0, mw = 0, m2r = 0, rd = 0, src = 0, br = 0;
        logic [3:0] a = 4'b0010;
        if (k == 0) begin
            pcw = 1; irl = 1;
        end else if (k == 2) begin
            case (kd)
                1:       a = r_code(fn);
                2, 3, 4: src = 1;
                5: begin a = 4'b0110; br = 1; pcw = z; end
                default: ;
            endcase
        end else if (k == 3 && (kd == 3 || kd == 4)) begin
            mr = (kd == 3); mw = (kd == 4);
        end else if (k == 3) begin
            rw = 1; rd = (kd == 1);
        end else if (k == 4) begin
            rw = 1; m2r = 1;
        end
        return {pcw, irl, rw, a, mr, mw, m2r, rd, src, br};
    endfunction

    task automatic check(input string req, input int step, input logic [13:0] exp);
        logic [13:0] act;
        act = {pc_write, ir_load, reg_write, alu_op, mem_read, mem_write,
               mem_to_reg, reg_dst, alu_src, branch};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s step %0d: actual %b expected %b", req, step, act, exp);
        end
    endtask

    // Call at a negedge where the unit sits in fetch; returns at the next fetch.
    task automatic run_instr(input logic [5:0] op, input logic [5:0] fn,
                             input logic z, input string req);
        int kd = kind_of(op, fn);
        int n  = len_of(kd);
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 0) begin opc = op; fnc = fn; zf = z; end
            #1;
            check((k < 2) ? "R1" : req, k, exp_vec(k, kd, fn, z));
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: outputs held low during reset, even with a taken branch presented
        opc = 6'b000100; zf = 1'b1;
        repeat (3) @(negedge clk);
        #1 check("R9", 0, 14'b0);
        rst = 1'b0;
        #1 check("R9", 0, exp_vec(0, 0, 6'b0, 1'b0));

        for (int i = 0; i < 16; i++) begin
            run_instr(VEC[i][16:11], VEC[i][10:5], VEC[i][4], req_name(int'(VEC[i][3:0])));
        end

        // R9: reset in the execute phase of a load
        opc = 6'b100011; fnc = 6'b000000; zf = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        #1 check("R9", 2, 14'b0);
        @(negedge clk);
        #1 check("R9", 3, 14'b0);
        @(negedge clk);
        rst = 1'b0;
        #1 check("R9", 0, exp_vec(0, 0, 6'b0, 1'b0));
        run_instr(6'b101011, 6'b000000, 1'b0, "R5");
        run_instr(6'b100011, 6'b000000, 1'b1, "R4");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule